// File: doc/BRIEF.md
# Ripple Down Counter with Terminal-Count Reload

This block is a small free-running down counter whose stages form a ripple chain. Each stage is a toggling D flip-flop. Stage 0 is clocked by the input clock, and every later stage is clocked by the rising edge of the stage below it. The counter starts at all ones and steps down to zero. While the count is zero it raises a terminal-count flag, and then it reloads all ones and starts again.

The reload does not come straight from the zero detect. A reload register samples the terminal-count flag on the input clock and drives the asynchronous presets of every stage for one clock period. This keeps the flag from racing the preset that would clear it. An external active-low preload input forces all ones at any time and overrides the reload path.

Because the stages ripple, the count is only valid once the chain has settled after a clock edge. Users should sample it away from the active edge.

Top module: `rdc_ripple_down`

## Requirements
- R1: While `load_n_i` is low, `count_o` reads 3'b111 and `tc_o` reads 0.
- R2: Driving `load_n_i` low forces `count_o` to 3'b111 at once, without waiting for a clock edge.
- R3: Outside a reload, each rising edge of `clk_i` lowers the settled `count_o` by exactly one, from 3'b111 down to 3'b000.
- R4: `tc_o` is 1 while the settled count is 3'b000 and 0 for every other count.
- R5: `tc_o` stays high for exactly one clock period per pass through the sequence.
- R6: At the edge after the count reaches 3'b000, the count becomes 3'b111. It holds 3'b111 at the following edge while the reload presets are still applied, and then continues with 3'b110.
- R7: In steady running, successive rises of `tc_o` are exactly 9 clock periods apart.
- R8: Asserting `load_n_i` while the count is 3'b000 cancels the pending reload. After release, the first clock edge gives 3'b110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; rising edge toggles stage 0 |
| load_n_i | input | 1 | Active-low asynchronous preload to all ones |
| count_o | output | 3 | Current count, stage outputs |
| tc_o | output | 1 | Terminal count, high when the count is zero |

## Verification
On every clock, the assertions check the single-step decrement, that the flag is followed by the reload and by the one-cycle hold of all ones, that the flag lasts one period, and that the count stays at all ones during preload. Only the bench scenarios can show the following: that preload acts without any clock edge, that a preload landing on the zero count cancels the pending reload, and that the flag repeats with a 9-period spacing over several passes. The bench samples only the settled count at the falling clock edge, so the brief intermediate codes that the ripple produces just after a rising edge are never judged.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
  localparam int unsigned RDC_WIDTH = 3;
endpackage

// File: rtl/rdc_toggle_stage.sv
`timescale 1ns/1ps
// One ripple stage: a D flip-flop whose inverted output feeds its D input.
module rdc_toggle_stage (
  input  logic stage_clk,
  input  logic preset_n,
  output logic q
);
  always_ff @(posedge stage_clk or negedge preset_n) begin
    if (!preset_n) q <= 1'b1;
    else           q <= ~q;
  end
endmodule

// File: rtl/rdc_zero_detect.sv
`timescale 1ns/1ps
// Wide NOR over the stage outputs.
module rdc_zero_detect #(
  parameter int unsigned WIDTH = rdc_pkg::RDC_WIDTH
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             zero_o
);
  assign zero_o = ~(|bits_i);
endmodule

// File: rtl/rdc_reload_reg.sv
`timescale 1ns/1ps
// Samples the terminal count on the input clock; a high output drives the presets.
module rdc_reload_reg (
  input  logic clk_i,
  input  logic load_n_i,
  input  logic tc_i,
  output logic reload_q
);
  always_ff @(posedge clk_i or negedge load_n_i) begin
    if (!load_n_i) reload_q <= 1'b0;
    else           reload_q <= tc_i;
  end
endmodule

// File: rtl/rdc_ripple_down.sv
`timescale 1ns/1ps
module rdc_ripple_down #(
  parameter int unsigned WIDTH = rdc_pkg::RDC_WIDTH
) (
  input  logic             clk_i,
  input  logic             load_n_i,
  output logic [WIDTH-1:0] count_o,
  output logic             tc_o
);
  logic reload_q;
  logic preset_n;

  // External preload and the registered reload share the preset net.
  assign preset_n = load_n_i & ~reload_q;

  // Rising-edge stages clocked from the previous true output count down.
  for (genvar g = 0; g < WIDTH; g++) begin : g_stage
    logic stage_clk;
    if (g == 0) begin : g_head
      assign stage_clk = clk_i;
    end else begin : g_tail
      assign stage_clk = count_o[g-1];
    end
    rdc_toggle_stage u_ff (
      .stage_clk (stage_clk),
      .preset_n  (preset_n),
      .q         (count_o[g])
    );
  end

  rdc_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .bits_i (count_o),
    .zero_o (tc_o)
  );

  rdc_reload_reg u_reload (
    .clk_i    (clk_i),
    .load_n_i (load_n_i),
    .tc_i     (tc_o),
    .reload_q (reload_q)
  );
endmodule

// File: rtl/rdc_ripple_down_chk.sv
`timescale 1ns/1ps
module rdc_ripple_down_chk #(
  parameter int unsigned WIDTH = rdc_pkg::RDC_WIDTH
) (
  input logic             clk_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] count_o,
  input logic             tc_o,
  input logic             reload_q
);
  logic low_q;
  always_ff @(posedge clk_i) low_q <= !load_n_i;

  // R1: preload held for a full period keeps all ones and no flag
  always_ff @(posedge clk_i) begin
    if (!load_n_i && low_q)
      p_preload_hold_r1: assert (count_o == '1 && !tc_o)
        else $error("preload hold violated");
  end

  p_step_r3: assert property (@(posedge clk_i) disable iff (!load_n_i)
    (count_o != '0 && !reload_q) |=> count_o == WIDTH'($past(count_o) - 1'b1));

  p_tc_pulse_r5: assert property (@(posedge clk_i) disable iff (!load_n_i)
    tc_o |=> !tc_o);

  p_tc_reload_r6: assert property (@(posedge clk_i) disable iff (!load_n_i)
    tc_o |=> (reload_q && count_o == '1));

  p_reload_hold_r6: assert property (@(posedge clk_i) disable iff (!load_n_i)
    reload_q |=> (!reload_q && count_o == '1));
endmodule

bind rdc_ripple_down rdc_ripple_down_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .load_n_i (load_n_i),
  .count_o  (count_o),
  .tc_o     (tc_o),
  .reload_q (reload_q)
);

// File: tb/rdc_ripple_down_tb.sv
`timescale 1ns/1ps
module rdc_ripple_down_tb;
  localparam int unsigned W = 3;

  typedef struct {
    logic [W-1:0] cnt;
    logic         tc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         load_n = 1'b0;
  logic [W-1:0] count;
  logic         tc;
  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];

  logic [W-1:0] m_cnt = '1;
  logic         m_hold = 1'b0;
  string        first_tag = "";

  int cyc = 0;
  int last_tc = -1;
  logic tc_d = 1'b0;
  logic track_gap = 1'b0;

  always #4 clk = ~clk;

  rdc_ripple_down u_dut (
    .clk_i    (clk),
    .load_n_i (load_n),
    .count_o  (count),
    .tc_o     (tc)
  );

  task automatic chk(input string req, input logic [W-1:0] act_c, input logic act_t,
                     input logic [W-1:0] exp_c, input logic exp_t_);
    checks++;
    if (act_c !== exp_c || act_t !== exp_t_) begin
      fails++;
      $display("FAIL %s: count=%b tc=%b expected count=%b tc=%b", req, act_c, act_t, exp_c, exp_t_);
    end
  endtask

  // Driver: model the requirements per rising edge and queue the settled result.
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      string t;
      @(posedge clk);
      if (m_cnt == '0) begin
        m_cnt = '1; m_hold = 1'b1; t = "R6";
      end else if (m_hold) begin
        m_hold = 1'b0; t = "R6";
      end else begin
        m_cnt = m_cnt - 1'b1; t = (m_cnt == '0) ? "R4" : "R3";
      end
      if (first_tag != "") begin t = first_tag; first_tag = ""; end
      e.cnt = m_cnt; e.tc = (m_cnt == '0); e.tag = t;
      sb_q.push_back(e);
    end
    @(negedge clk); #1;
  endtask

  // Monitor: compare settled outputs at the falling edge, never mid-ripple.
  always @(negedge clk) begin
    cyc++;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, count, tc, e.cnt, e.tc);
    end
    if (track_gap && tc && !tc_d) begin
      if (last_tc >= 0) begin
        checks++;
        if (cyc - last_tc != 9) begin
          fails++;
          $display("FAIL R7: tc spacing=%0d expected 9", cyc - last_tc);
        end
      end
      last_tc = cyc;
    end
    if (track_gap && tc && tc_d) begin
      checks++; fails++;
      $display("FAIL R5: tc=1 for two periods expected 1 period");
    end
    tc_d = tc;
  end

  task automatic release_load();
    load_n = 1'b1; m_cnt = '1; m_hold = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", count, tc, 3'b111, 1'b0);
    @(negedge clk); #1;
    chk("R1", count, tc, 3'b111, 1'b0);

    // Full passes: decrement, flag, reload, hold, spacing.
    release_load();
    track_gap = 1'b1;
    run(30);
    track_gap = 1'b0;
    checks++;
    if (last_tc < 0) begin
      fails++;
      $display("FAIL R7: tc never rose expected a rise");
    end

    // Asynchronous preload in the middle of a pass.
    release_load(); load_n = 1'b0; #10;
    release_load();
    run(3);
    chk("R3", count, tc, 3'b100, 1'b0);
    load_n = 1'b0;
    #1;
    chk("R2", count, tc, 3'b111, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    chk("R1", count, tc, 3'b111, 1'b0);

    // Preload landing on the zero count cancels the pending reload.
    release_load();
    run(7);
    chk("R4", count, tc, 3'b000, 1'b1);
    load_n = 1'b0;
    #1;
    chk("R2", count, tc, 3'b111, 1'b0);
    repeat (2) @(negedge clk);
    #1;
    release_load();
    first_tag = "R8";
    run(12);

    #20;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule